// File: doc/BRIEF.md
# Four-Accumulator Multiply-Accumulate Unit

This block is a multiply-accumulate datapath with four accumulators. Each accumulator holds 32 bits and has a 16-bit guard extension above it, so every accumulator is in effect a 48-bit value. In one clock cycle the block multiplies two 16-bit operands and adds the product to, or subtracts it from, the accumulator chosen by a 2-bit select.

A status register holds four fields:
- a run-time mode field: saturate on overflow, signed or unsigned operands, fractional or integer format, and rounding or truncation;
- four condition flags, which describe the latest operation;
- one sticky overflow bit per accumulator;
- zeros in all upper bits.

Software reaches every register through a simple word-wide register port. Writes take effect on the clock edge. Reads are combinational. The extension halves of the accumulators are packed in pairs into two words. Four read-only addresses return the upper half of each accumulator, rounded when the mode asks for it. A 16-bit mask register is also provided. It is plain storage.

Top module: `mac_quad`

## Requirements
- R1: After reset, every readable address (0 to 11) reads zero.
- R2: Register map for `reg_addr`:
  - 0 to 3 are accumulators 0 to 3, read and written as 32-bit words.
  - 6 is the mask: it keeps `reg_wdata[15:0]` and reads back with bits 31:16 at zero.
  - 7 is the status register, with bits 31:12 reading zero.
  - Addresses 12 to 15 read zero and ignore writes.
- R3: Address 4 packs the extensions of accumulators 0 and 1. Address 5 packs those of accumulators 2 and 3. In each word, bits 15:0 hold the extension of the even accumulator and bits 31:16 that of the odd one. An accumulator's 48-bit value is {extension, accumulator}.
- R4: Status bit 6 set selects signed operands, so the product is sign-extended to 48 bits. Bit 6 clear selects unsigned operands, so the product is zero-extended. When `op_valid` is high, the 48-bit value of accumulator `op_sel` is replaced by its value plus the product, or minus the product when `op_sub` is high.
- R5: Status bit 5 set selects fractional format: the product is shifted left by one bit before accumulation. Bit 5 clear selects integer format, with no shift.
- R6: After each operation, status bit 3 (N) equals bit 47 of the stored 48-bit result. Status bit 2 (Z) is set exactly when the stored 48-bit result is zero.
- R7: After each operation, status bit 0 (EV) is set when the 48-bit addition overflows. That is a two's-complement overflow in signed mode, or a carry or borrow out of bit 47 in unsigned mode. Status bit 1 (V) is set when the exact result does not fit 32 bits in the current signedness, and V is always set when EV is set.
- R8: With status bit 7 set and V set, the stored result is clamped.
  - Signed mode: the accumulator becomes 0x7FFFFFFF with extension 0x0000, or 0x80000000 with extension 0xFFFF, following the sign of the exact result.
  - Unsigned mode: the accumulator becomes 0xFFFFFFFF, or 0x00000000 when a subtraction went below zero, with extension 0x0000.
  - Without saturation the wrapped 48-bit result is stored.
- R9: Status bits 11:8 are sticky overflow flags, bit 8 for accumulator 0.
  - An operation that sets V also sets the flag of its accumulator.
  - A flag stays set until software writes 0 to it through address 7.
  - Writing address 7 also loads the mode and condition bits.
- R10: Addresses 8 to 11 return, in bits 15:0, the upper 16 bits of accumulators 0 to 3; bits 31:16 read zero.
  - When status bits 5 and 4 are both set, the value is rounded to nearest by adding 0x8000 first. It clamps to 0x7FFF (signed) or 0xFFFF (unsigned) if that addition overflows.
  - Otherwise it is the truncated value of bits 31:16.
- R11: When an operation and a register write happen in the same cycle, the operation uses the mode held before the edge. Its result wins over the write for its own accumulator, its own extension and the condition flags. The write still applies to every other field.
- R12: With `op_valid` low and no write, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Perform one multiply-accumulate this cycle |
| op_sub | input | 1 | Subtract the product instead of adding it |
| op_sel | input | 2 | Target accumulator |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |

## Verification
The in-module assertions check the following on every cycle:
- the sticky overflow bits stay set unless the status register is written;
- an extension overflow always comes with a 32-bit overflow;
- the zero flag matches the stored 48-bit value;
- after a saturating operation the extension is consistent with the accumulator;
- an idle cycle changes nothing.

The bench scenarios cover what a single-cycle property cannot show:
- the exact arithmetic across signed, unsigned, integer and fractional modes;
- the clamp values themselves;
- the packed extension layout;
- rounded upper-half reads;
- the ordering when an operation collides with a register write in the same cycle.

// File: rtl/mac_quad_pkg.sv
package mac_quad_pkg;
    localparam int OPW    = 16;
    localparam int ACCW   = 32;
    localparam int EXTW   = 16;
    localparam int XW     = ACCW + EXTW;
    localparam int NACC   = 4;
    localparam int SELW   = $clog2(NACC);
    localparam int ADDRW  = 4;
    localparam int DATAW  = 32;
    localparam int MASKW  = 16;

    localparam logic [ADDRW-1:0] A_EXT_LO = 4'd4;
    localparam logic [ADDRW-1:0] A_EXT_HI = 4'd5;
    localparam logic [ADDRW-1:0] A_MASK   = 4'd6;
    localparam logic [ADDRW-1:0] A_STAT   = 4'd7;
    localparam logic [ADDRW-1:0] A_HALF0  = 4'd8;

    typedef struct packed {
        logic sat;
        logic sgn;
        logic frac;
        logic rnd;
    } mode_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic ev;
    } flags_t;

    typedef struct packed {
        logic [NACC-1:0][ACCW-1:0] acc;
        logic [NACC-1:0][EXTW-1:0] ext;
        logic [MASKW-1:0]          mask;
        logic [NACC-1:0]           pav;
        mode_t                     mode;
        flags_t                    flags;
    } state_t;
endpackage

// File: rtl/mac_quad_mul.sv
module mac_quad_mul
    import mac_quad_pkg::*;
#(
    parameter int W  = OPW,
    parameter int PW = XW
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          sgn_i,
    input  logic          frac_i,
    output logic [PW-1:0] prod_o
);
    localparam int RW = 2 * W + 2;

    logic signed [W:0]    a_x, b_x;
    logic signed [RW-1:0] raw;
    logic [PW-1:0]        wide;

    always_comb begin
        a_x    = $signed({sgn_i & a_i[W-1], a_i});
        b_x    = $signed({sgn_i & b_i[W-1], b_i});
        raw    = a_x * b_x;
        wide   = {{(PW-RW){raw[RW-1]}}, raw};
        prod_o = frac_i ? {wide[PW-2:0], 1'b0} : wide;
    end
endmodule

// File: rtl/mac_quad_accum.sv
module mac_quad_accum
    import mac_quad_pkg::*;
#(
    parameter int AW = ACCW,
    parameter int EW = EXTW
) (
    input  logic [AW-1:0]    acc_i,
    input  logic [EW-1:0]    ext_i,
    input  logic [AW+EW-1:0] prod_i,
    input  logic             sub_i,
    input  logic             sgn_i,
    input  logic             sat_i,
    output logic [AW-1:0]    acc_o,
    output logic [EW-1:0]    ext_o,
    output flags_t           flags_o
);
    localparam int TW = AW + EW;

    logic [TW:0]   old_x, prod_x, sum_x;
    logic [TW-1:0] wrap, clamp, res;
    logic          ev, fits, ovf, neg;

    always_comb begin
        old_x  = {sgn_i & ext_i[EW-1], ext_i, acc_i};
        prod_x = {sgn_i & prod_i[TW-1], prod_i};
        sum_x  = sub_i ? (old_x - prod_x) : (old_x + prod_x);
        wrap   = sum_x[TW-1:0];
        ev     = sgn_i ? (sum_x[TW] ^ sum_x[TW-1]) : sum_x[TW];
        if (sgn_i)
            fits = (wrap[TW-1:AW-1] == '0) || (wrap[TW-1:AW-1] == '1);
        else
            fits = (wrap[TW-1:AW] == '0);
        ovf = ev | ~fits;
        if (sgn_i)
            neg = ev ? ~wrap[TW-1] : wrap[TW-1];
        else
            neg = ev & sub_i;
        if (sgn_i)
            clamp = neg ? {{(EW+1){1'b1}}, {(AW-1){1'b0}}}
                        : {{(EW+1){1'b0}}, {(AW-1){1'b1}}};
        else
            clamp = neg ? '0 : {{EW{1'b0}}, {AW{1'b1}}};
        res      = (sat_i && ovf) ? clamp : wrap;
        acc_o    = res[AW-1:0];
        ext_o    = res[TW-1:AW];
        flags_o.n  = res[TW-1];
        flags_o.z  = (res == '0);
        flags_o.v  = ovf;
        flags_o.ev = ev;
    end
endmodule

// File: rtl/mac_quad_rdmux.sv
module mac_quad_rdmux
    import mac_quad_pkg::*;
(
    input  state_t           st_i,
    input  logic [ADDRW-1:0] addr_i,
    output logic [DATAW-1:0] rdata_o
);
    localparam int HW = ACCW / 2;

    logic [SELW-1:0] idx;
    logic [ACCW:0]   rsum;
    logic [HW:0]     rhi;
    logic [HW-1:0]   half;

    always_comb begin
        idx  = addr_i[SELW-1:0];
        rsum = {1'b0, st_i.acc[idx]} + {{(HW+1){1'b0}}, 1'b1, {(HW-1){1'b0}}};
        rhi  = rsum[ACCW:HW];
        if (st_i.mode.frac && st_i.mode.rnd) begin
            if (st_i.mode.sgn)
                half = (!st_i.acc[idx][ACCW-1] && rhi[HW-1]) ? {1'b0, {(HW-1){1'b1}}} : rhi[HW-1:0];
            else
                half = rhi[HW] ? '1 : rhi[HW-1:0];
        end else begin
            half = st_i.acc[idx][ACCW-1:HW];
        end

        rdata_o = '0;
        if (addr_i < ADDRW'(NACC)) begin
            rdata_o = st_i.acc[idx];
        end else if (addr_i >= A_HALF0 && addr_i < A_HALF0 + ADDRW'(NACC)) begin
            rdata_o = {{(DATAW-HW){1'b0}}, half};
        end else begin
            case (addr_i)
                A_EXT_LO: rdata_o = {st_i.ext[1], st_i.ext[0]};
                A_EXT_HI: rdata_o = {st_i.ext[3], st_i.ext[2]};
                A_MASK:   rdata_o = {{(DATAW-MASKW){1'b0}}, st_i.mask};
                A_STAT:   rdata_o = {{(DATAW-12){1'b0}}, st_i.pav, st_i.mode, st_i.flags};
                default:  rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/mac_quad.sv
module mac_quad
    import mac_quad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic [1:0]       op_sel,
    input  logic [15:0]      op_a,
    input  logic [15:0]      op_b,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata
);
    state_t         st_d, st_q;
    logic [XW-1:0]  prod;
    logic [ACCW-1:0] new_acc;
    logic [EXTW-1:0] new_ext;
    flags_t         new_flags;

    mac_quad_mul #(.W(OPW), .PW(XW)) u_mul (
        .a_i    (op_a),
        .b_i    (op_b),
        .sgn_i  (st_q.mode.sgn),
        .frac_i (st_q.mode.frac),
        .prod_o (prod)
    );

    mac_quad_accum #(.AW(ACCW), .EW(EXTW)) u_accum (
        .acc_i   (st_q.acc[op_sel]),
        .ext_i   (st_q.ext[op_sel]),
        .prod_i  (prod),
        .sub_i   (op_sub),
        .sgn_i   (st_q.mode.sgn),
        .sat_i   (st_q.mode.sat),
        .acc_o   (new_acc),
        .ext_o   (new_ext),
        .flags_o (new_flags)
    );

    mac_quad_rdmux u_rdmux (
        .st_i    (st_q),
        .addr_i  (reg_addr),
        .rdata_o (reg_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (reg_addr < ADDRW'(NACC)) begin
                st_d.acc[reg_addr[SELW-1:0]] = reg_wdata;
            end else begin
                case (reg_addr)
                    A_EXT_LO: begin
                        st_d.ext[0] = reg_wdata[EXTW-1:0];
                        st_d.ext[1] = reg_wdata[2*EXTW-1:EXTW];
                    end
                    A_EXT_HI: begin
                        st_d.ext[2] = reg_wdata[EXTW-1:0];
                        st_d.ext[3] = reg_wdata[2*EXTW-1:EXTW];
                    end
                    A_MASK: st_d.mask = reg_wdata[MASKW-1:0];
                    A_STAT: begin
                        st_d.pav   = reg_wdata[11:8];
                        st_d.mode  = mode_t'(reg_wdata[7:4]);
                        st_d.flags = flags_t'(reg_wdata[3:0]);
                    end
                    default: ;
                endcase
            end
        end
        if (op_valid) begin
            st_d.acc[op_sel] = new_acc;
            st_d.ext[op_sel] = new_ext;
            st_d.flags       = new_flags;
            st_d.pav[op_sel] = st_d.pav[op_sel] | new_flags.v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12: an idle cycle leaves every register untouched
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !reg_wr) |=> $stable(st_q));

    // R7: extension overflow implies 32-bit overflow after an operation
    p_ev_implies_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (!st_q.flags.ev || st_q.flags.v));

    // R6: zero flag agrees with the stored 48-bit value
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (st_q.flags.z ==
            ({st_q.ext[$past(op_sel)], st_q.acc[$past(op_sel)]} == '0)));

    // R8: a saturating operation leaves a result that fits 32 bits
    p_sat_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && st_q.mode.sat) |=>
            (st_q.ext[$past(op_sel)] ==
             ($past(st_q.mode.sgn) ? {EXTW{st_q.acc[$past(op_sel)][ACCW-1]}} : '0)));

    // R9: sticky overflow flags drop only on a status write
    for (genvar gi = 0; gi < NACC; gi++) begin : g_sticky
        p_pav_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pav[gi] && !(reg_wr && reg_addr == A_STAT)) |=> st_q.pav[gi]);
    end
endmodule

// File: tb/mac_quad_test.sv
`timescale 1ns/1ps
module mac_quad_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_sub = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mac_quad uut (.*);

    // vector: mode[122:119] sub[118] sel[117:116] a[115:100] b[99:84]
    //         init[83:52] exp_acc[51:20] exp_ext[19:4] exp_flags[3:0]
    localparam int NV = 12;
    localparam logic [122:0] VEC [NV] = '{
        {4'b0100, 1'b0, 2'd0, 16'h0003, 16'h0005, 32'h0000000A, 32'h00000019, 16'h0000, 4'h0},
        {4'b0100, 1'b1, 2'd1, 16'hFFFE, 16'h0007, 32'h00000004, 32'h00000012, 16'h0000, 4'h0},
        {4'b0100, 1'b0, 2'd2, 16'hFFFE, 16'h0003, 32'h00000000, 32'hFFFFFFFA, 16'hFFFF, 4'h8},
        {4'b0000, 1'b0, 2'd3, 16'hFFFF, 16'hFFFF, 32'h00000000, 32'hFFFE0001, 16'h0000, 4'h0},
        {4'b0000, 1'b1, 2'd0, 16'h0001, 16'h0001, 32'h00000000, 32'hFFFFFFFF, 16'hFFFF, 4'hB},
        {4'b0100, 1'b0, 2'd1, 16'hFFFE, 16'h0003, 32'h00000006, 32'h00000000, 16'h0000, 4'h4},
        {4'b0110, 1'b0, 2'd2, 16'h4000, 16'h4000, 32'h00000000, 32'h20000000, 16'h0000, 4'h0},
        {4'b0110, 1'b0, 2'd3, 16'h8000, 16'h8000, 32'h00000000, 32'h80000000, 16'h0000, 4'h2},
        {4'b1110, 1'b0, 2'd3, 16'h8000, 16'h8000, 32'h00000000, 32'h7FFFFFFF, 16'h0000, 4'h2},
        {4'b1000, 1'b1, 2'd0, 16'h0001, 16'h0001, 32'h00000000, 32'h00000000, 16'h0000, 4'h7},
        {4'b1000, 1'b0, 2'd1, 16'h0001, 16'h0001, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 4'h2},
        {4'b0010, 1'b0, 2'd2, 16'h8000, 16'h8000, 32'h00000000, 32'h80000000, 16'h0000, 4'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic mac(input logic sub, input logic [1:0] sel,
                       input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_sub = sub; op_sel = sel; op_a = a; op_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] d, ew, st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 12; i++) begin
            rd(4'(i), d);
            check($sformatf("R1 reset addr %0d", i), d, 32'h0);
        end

        // R4 R5 R6 R7 R8: table walk
        for (int i = 0; i < NV; i++) begin
            logic [122:0] v;
            logic [1:0]   sel;
            logic [3:0]   ef;
            v   = VEC[i];
            sel = v[117:116];
            ef  = v[3:0];
            wr(4'd7, {24'h0, v[122:119], 4'h0});
            wr(4'd4, 32'h0);
            wr(4'd5, 32'h0);
            wr({2'b00, sel}, v[83:52]);
            mac(v[118], sel, v[115:100], v[99:84]);
            rd({2'b00, sel}, d);
            check($sformatf("R4 R5 R8 vec %0d acc", i), d, v[51:20]);
            rd(sel[1] ? 4'd5 : 4'd4, ew);
            check($sformatf("R3 R8 vec %0d ext", i), {16'h0, sel[0] ? ew[31:16] : ew[15:0]},
                  {16'h0, v[19:4]});
            rd(4'd7, st);
            check($sformatf("R6 R7 R9 vec %0d status", i), st,
                  {20'h0, ef[1] ? (4'b0001 << sel) : 4'b0000, v[122:119], ef});
        end

        // R2: register map
        wr(4'd6, 32'hABCD1234);
        rd(4'd6, d);   check("R2 mask width", d, 32'h00001234);
        wr(4'd7, 32'hFFFFFFFF);
        rd(4'd7, d);   check("R2 status pad", d, 32'h00000FFF);
        wr(4'd2, 32'hCAFEF00D);
        rd(4'd2, d);   check("R2 acc2 write", d, 32'hCAFEF00D);
        wr(4'd13, 32'h12345678);
        rd(4'd13, d);  check("R2 unused addr", d, 32'h0);

        // R3: packed extensions
        wr(4'd7, 32'h40);
        wr(4'd4, 32'h0000FFFF);
        wr(4'd0, 32'hFFFFFFFF);
        mac(1'b0, 2'd0, 16'h0001, 16'h0001);
        rd(4'd0, d);   check("R3 acc0 minus one plus one", d, 32'h0);
        rd(4'd4, d);   check("R3 ext low half is acc0", d, 32'h0);
        rd(4'd7, d);   check("R3 R6 zero flag", d, 32'h44);
        wr(4'd5, 32'h12345678);
        rd(4'd5, d);   check("R3 ext23 readback", d, 32'h12345678);

        // R7 R9: signed 48-bit overflow, sticky flag
        wr(4'd5, 32'h00007FFF);
        wr(4'd2, 32'hFFFFFFFF);
        mac(1'b0, 2'd2, 16'h0001, 16'h0001);
        rd(4'd2, d);   check("R7 acc2 wrap", d, 32'h0);
        rd(4'd5, d);   check("R7 ext wrap", d, 32'h00008000);
        rd(4'd7, d);   check("R7 EV status", d, 32'h44B);
        wr(4'd1, 32'h0);
        mac(1'b0, 2'd1, 16'h0002, 16'h0003);
        rd(4'd7, d);   check("R9 sticky stays", d, 32'h440);
        wr(4'd7, 32'h40);
        rd(4'd7, d);   check("R9 cleared by write", d, 32'h40);

        // R10: upper-half reads
        wr(4'd7, 32'h70);
        wr(4'd0, 32'h12348000);
        rd(4'd8, d);   check("R10 rounded", d, 32'h1235);
        wr(4'd7, 32'h60);
        rd(4'd8, d);   check("R10 truncated", d, 32'h1234);
        wr(4'd7, 32'h50);
        rd(4'd8, d);   check("R10 integer no rounding", d, 32'h1234);
        wr(4'd7, 32'h70);
        wr(4'd1, 32'h7FFF8000);
        rd(4'd9, d);   check("R10 signed clamp", d, 32'h7FFF);
        wr(4'd7, 32'h30);
        wr(4'd3, 32'hFFFF8000);
        rd(4'd11, d);  check("R10 unsigned clamp", d, 32'hFFFF);

        // R11: collision of operation and write
        wr(4'd7, 32'h40);
        wr(4'd1, 32'd10);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h100;
        op_valid = 1'b1; op_sub = 1'b0; op_sel = 2'd1; op_a = 16'd2; op_b = 16'd3;
        @(negedge clk);
        reg_wr = 1'b0; op_valid = 1'b0;
        rd(4'd1, d);   check("R11 op wins over write", d, 32'd16);
        wr(4'd3, 32'h0);
        wr(4'd5, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 32'h0;
        op_valid = 1'b1; op_sub = 1'b1; op_sel = 2'd3; op_a = 16'd1; op_b = 16'd1;
        @(negedge clk);
        reg_wr = 1'b0; op_valid = 1'b0;
        rd(4'd7, d);   check("R11 old mode used, new mode kept", d, 32'h08);
        rd(4'd3, d);   check("R11 acc3 signed result", d, 32'hFFFFFFFF);
        rd(4'd5, d);   check("R11 ext3", d, 32'hFFFF0000);

        // R12: idle cycles and unrelated writes change nothing
        repeat (5) @(negedge clk);
        wr(4'd6, 32'h5555);
        rd(4'd1, d);   check("R12 acc1 held", d, 32'd16);
        rd(4'd7, d);   check("R12 status held", d, 32'h08);
        rd(4'd3, d);   check("R12 acc3 held", d, 32'hFFFFFFFF);

        finish_up();
    end
endmodule